// File: doc/BRIEF.md
# Configurable programmable logic array

This block is a small sum-of-products engine whose function is held entirely in configuration registers. The literal plane forms a set of product terms. Each term is the AND of a chosen set of true or complemented inputs. The sum plane then drives each output as the OR of any chosen set of those terms. Both planes are programmable, and one product term may feed any number of outputs. A shared term is therefore evaluated once and reused.

Software or a boot sequencer loads the personality one product-term row per clock. A row write carries the literal settings for every input and the output-connection mask for that term. From `din` to `dout` the path is purely combinational. The stored configuration changes only on a write or on reset. An empty literal row yields a term that is always 1. An output with an empty connection column is always 0. Both constants therefore fall out of the cleared configuration with no special handling.

Top module: `pla_array`

## Requirements
- R1: Each input i has a 2-bit setting at `prog_lits[2i+1:2i]`. The term uses the true input for 2'b10, the complemented input for 2'b01, and ignores the input for 2'b00. The term is the AND of all literals that take part.
- R2: The setting 2'b11 on any input forces that product term to 0 for every input value.
- R3: A product term whose settings are all 2'b00 evaluates to constant 1.
- R4: Bit o of a row's `prog_outs` connects that term to output o. Each output is the OR of its connected terms.
- R5: A single product term connected to several outputs drives all of them at the same time.
- R6: An output with no term connected reads 0 for every input value.
- R7: When `prog_we` is high at a rising clock edge, exactly the row addressed by `prog_term` is replaced, and every other row keeps its contents. The new row affects `dout` only after that edge. With `prog_we` low, the configuration does not change.
- R8: A synchronous reset (`rst` high at a rising edge) clears every row. Afterwards `dout` is 0 for all input values.
- R9: `dout` follows a change of `din` without waiting for a clock edge.
- R10: With inputs A=`din[2]`, B=`din[1]` and C=`din[0]`, and the terms A, B'C', AC', AB and B'C, the array can be loaded to give F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A on `dout[0..3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset, clears the configuration |
| prog_we | input | 1 | Row write enable |
| prog_term | input | ROW_W | Index of the product-term row to write |
| prog_lits | input | 2*N_IN | Literal settings, 2 bits per input |
| prog_outs | input | N_OUT | Output-connection mask for the row |
| din | input | N_IN | Logic inputs |
| dout | output | N_OUT | Logic outputs |

## Verification
The array is exercised exhaustively over all eight input codes in several configurations. These are a cleared array, a single empty term, a contradictory term, single true and single complemented literals, and the full four-function example. The contradictory term is told apart from an ignored input because its output stays 0 even where the plain literal would be 1. The example load uses shared terms (A, AB, B'C'), so a reference computed directly from the boolean equations reveals any mix-up between term reuse and term placement. Row-isolation and write-timing checks look at `dout` before and after the write edge. They also repeat a write with the enable low, to show that only the addressed row changes and only when enabled.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LIT_OFF  = 2'b00,
        LIT_NEG  = 2'b01,
        LIT_POS  = 2'b10,
        LIT_VOID = 2'b11
    } lit_sel_e;

    function automatic logic lit_pass(lit_sel_e sel, logic x);
        case (sel)
            LIT_OFF: return 1'b1;
            LIT_NEG: return ~x;
            LIT_POS: return x;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pla_plane_store.sv
module pla_plane_store #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ROW_W-1:0]                  row,
    input  logic [2*N_IN-1:0]                 lits,
    input  logic [N_OUT-1:0]                  outs,
    output logic [N_TERM-1:0][2*N_IN-1:0]     and_cfg,
    output logic [N_TERM-1:0][N_OUT-1:0]      or_cfg
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        logic hit;
        assign hit = we && (row == ROW_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                and_cfg[t] <= '0;
                or_cfg[t]  <= '0;
            end else if (hit) begin
                and_cfg[t] <= lits;
                or_cfg[t]  <= outs;
            end
        end

        // R7: addressed row takes the written data
        assert_row_load_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(we) && $past(row) == ROW_W'(t))
            |-> (and_cfg[t] == $past(lits) && or_cfg[t] == $past(outs)));

        // R7: any other row is left alone
        assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !($past(we) && $past(row) == ROW_W'(t)))
            |-> ($stable(and_cfg[t]) && $stable(or_cfg[t])));
    end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg,
    input  logic [N_IN-1:0]               din,
    output logic [N_TERM-1:0]             term
);
    import pla_pkg::*;

    function automatic logic row_has_void(logic [2*N_IN-1:0] r);
        logic v;
        v = 1'b0;
        for (int i = 0; i < N_IN; i++) v |= (r[2*i+:2] == 2'b11);
        return v;
    endfunction

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        always_comb begin
            term[t] = 1'b1;
            for (int i = 0; i < N_IN; i++)
                term[t] &= lit_pass(lit_sel_e'(and_cfg[t][2*i+:2]), din[i]);
        end

        assert_empty_term_one_R3: assert property (@(posedge clk) disable iff (rst)
            (and_cfg[t] == '0) |-> term[t]);

        assert_void_term_zero_R2: assert property (@(posedge clk) disable iff (rst)
            row_has_void(and_cfg[t]) |-> !term[t]);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_TERM-1:0][N_OUT-1:0] or_cfg,
    input  logic [N_TERM-1:0]            term,
    output logic [N_OUT-1:0]             dout
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] col;
        always_comb begin
            for (int t = 0; t < N_TERM; t++) col[t] = or_cfg[t][o];
        end

        always_comb begin
            dout[o] = 1'b0;
            for (int t = 0; t < N_TERM; t++) dout[o] |= col[t] & term[t];
        end

        assert_empty_out_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (col == '0) |-> !dout[o]);

        assert_out_needs_term_R4: assert property (@(posedge clk) disable iff (rst)
            dout[o] |-> ((col & term) != '0));
    end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 4,
    localparam int ROW_W = pla_pkg::idx_width(N_TERM),
    localparam int LIT_W = 2 * N_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_we,
    input  logic [ROW_W-1:0] prog_term,
    input  logic [LIT_W-1:0] prog_lits,
    input  logic [N_OUT-1:0] prog_outs,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout
);

    logic [N_TERM-1:0][LIT_W-1:0] and_cfg;
    logic [N_TERM-1:0][N_OUT-1:0] or_cfg;
    logic [N_TERM-1:0]            term;

    pla_plane_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W)
    ) u_store (
        .clk(clk), .rst(rst), .we(prog_we), .row(prog_term),
        .lits(prog_lits), .outs(prog_outs),
        .and_cfg(and_cfg), .or_cfg(or_cfg)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .clk(clk), .rst(rst), .and_cfg(and_cfg), .din(din), .term(term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .clk(clk), .rst(rst), .or_cfg(or_cfg), .term(term), .dout(dout)
    );

endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;

    localparam int NI = 3;
    localparam int NT = 8;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_we = 1'b0;
    logic [2:0]    prog_term = '0;
    logic [5:0]    prog_lits = '0;
    logic [NO-1:0] prog_outs = '0;
    logic [NI-1:0] din = '0;
    logic [NO-1:0] dout;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    localparam logic [1:0] OFF = 2'b00, NEG = 2'b01, POS = 2'b10, VOID = 2'b11;

    pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u_pla_array (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_term(prog_term),
        .prog_lits(prog_lits), .prog_outs(prog_outs), .din(din), .dout(dout)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [NO-1:0] act, logic [NO-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: dout=%b expected=%b (din=%b)", req, act, exp, din);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic write_row(int row, logic [1:0] a, logic [1:0] b, logic [1:0] c,
                             logic [NO-1:0] outs);
        @(negedge clk);
        prog_we = 1'b1; prog_term = 3'(row); prog_lits = {a, b, c}; prog_outs = outs;
        @(posedge clk); #1;
        prog_we = 1'b0;
    endtask

    function automatic logic [NO-1:0] ref_fn(logic [2:0] v);
        logic a, b, c;
        {a, b, c} = v;
        return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
    endfunction

    // R8: cleared array gives 0 everywhere
    task automatic t_reset();
        do_reset();
        for (int v = 0; v < 8; v++) begin
            din = 3'(v); #1; chk("R8 reset clears", dout, '0);
        end
    endtask

    // R3 / R6: empty term constant 1 on output 0, other outputs unconnected
    task automatic t_constants();
        do_reset();
        write_row(0, OFF, OFF, OFF, 4'b0001);
        for (int v = 0; v < 8; v++) begin
            din = 3'(v); #1;
            chk("R3 empty term is 1 / R6 empty outputs are 0", dout, 4'b0001);
        end
    endtask

    // R2: a void setting kills the term even where the other literal would pass
    task automatic t_void();
        do_reset();
        write_row(0, POS, OFF, VOID, 4'b0001);
        for (int v = 0; v < 8; v++) begin
            din = 3'(v); #1; chk("R2 void setting forces 0", dout, 4'b0000);
        end
    endtask

    // R1: single true and single complemented literal
    task automatic t_literals();
        do_reset();
        write_row(0, POS, OFF, OFF, 4'b0001);
        write_row(1, OFF, NEG, OFF, 4'b0010);
        for (int v = 0; v < 8; v++) begin
            logic [2:0] x = 3'(v);
            din = x; #1;
            chk("R1 true A on out0, complement B on out1", dout, {2'b00, ~x[1], x[2]});
        end
    endtask

    // R7: write timing, row isolation, disabled write
    task automatic t_write();
        do_reset();
        write_row(0, OFF, OFF, OFF, 4'b0001);
        din = 3'b000;
        @(negedge clk);
        prog_we = 1'b1; prog_term = 3'd1; prog_lits = 6'b000000; prog_outs = 4'b0100;
        #1; chk("R7 no effect before edge", dout, 4'b0001);
        @(posedge clk); #1; prog_we = 1'b0;
        chk("R7 visible after edge, row 0 kept", dout, 4'b0101);
        @(negedge clk);
        prog_term = 3'd0; prog_lits = 6'b111111; prog_outs = 4'b1000;
        @(posedge clk); #1;
        chk("R7 write disabled has no effect", dout, 4'b0101);
    endtask

    // R10 / R4 / R5 / R9: full example with shared terms
    task automatic t_example();
        do_reset();
        write_row(0, POS, OFF, OFF, 4'b1001);
        write_row(1, OFF, NEG, NEG, 4'b0101);
        write_row(2, POS, OFF, NEG, 4'b0010);
        write_row(3, POS, POS, OFF, 4'b0110);
        write_row(4, OFF, NEG, POS, 4'b1000);
        @(negedge clk);
        for (int v = 0; v < 8; v++) begin
            din = 3'(v); #1;
            chk("R10 example functions, R4 OR of terms, R5 shared terms, R9 comb path",
                dout, ref_fn(3'(v)));
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_constants();
        t_void();
        t_literals();
        t_write();
        t_example();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule